// File: doc/BRIEF.md
# Triggered Chamber Event Record Builder

This block collects the digitised hit times of one detector chamber and, when a trigger arrives, turns them into one variable-length readout record that leaves as a stream of 32-bit words with valid/ready flow control. Between triggers, each hit arrives on a small input port as a timing-group number and a pair of 16-bit time codes: the leading edge and the trailing edge. The block keeps up to sixteen such pairs per group, in the order they arrive. There are eight groups by default.

A trigger strobe carries a 32-bit event number and a mode bit. It also captures the 128-bit strip hit pattern, the 50-bit arrival time and the 16-bit chamber identifier that are present on the inputs in the same cycle. The record starts with eight header words. Then comes one tag word per timing group, in ascending group order, and each tag word is followed by that group's hit pairs. In full mode every group is sent. In zero-suppressed mode, groups without hits are left out.

While a record is leaving, the block is busy. A trigger that arrives during that time is counted and thrown away, and hit inputs are ignored. When the last word has been accepted, the hit store is emptied for the next event.

Top module: `ev_record_builder`

## Requirements
- R1: After reset, `busy` and `rec_valid` are low and `drop_cnt` is zero.
- R2: A trigger while idle starts a record in the next cycle. Header words 0 to 7 are, in this order: the event number; {chamber id[31:16], packet info[15:0]}; {14 zero bits, arrival time[49:32]}; arrival time[31:0]; strip pattern bits [127:96], [95:64], [63:32] and [31:0].
- R3: Packet info bits [15:14] carry the mode (00 = full, 01 = zero-suppressed). Bits [13:0] carry the total record length in 32-bit words, header included.
- R4: A tag word is laid out as follows: bit 31 is the overflow flag, bits [20:16] are the kept hit count, bits [15:0] are the group number, and all other bits are zero. In full mode, a tag word is sent for every group in ascending order, including groups with zero hits.
- R5: Each hit word is {leading time[31:16], trailing time[15:0]}. A group's hit words follow its tag word in arrival order.
- R6: In zero-suppressed mode, only groups with at least one hit get a tag word. An event with no hits is then header only, 8 words long.
- R7: When a group receives more than 16 hits, only the first 16 are kept and bit 31 of its tag word is set.
- R8: A trigger while busy increments `drop_cnt`, which saturates at its maximum. The trigger does not change the record being sent and no record is queued for it.
- R9: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and `rec_data` stays unchanged.
- R10: `rec_last` is high only on the final word of a record, and `busy` falls after that word is accepted. Hits presented while busy are ignored, and the hit store is empty after each record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | Hit pair present |
| hit_chan | input | 3 | Timing group of the hit |
| hit_start | input | 16 | Leading edge time code |
| hit_stop | input | 16 | Trailing edge time code |
| trig | input | 1 | Trigger strobe |
| trig_evt | input | 32 | Event number carried by the trigger |
| trig_zs | input | 1 | 1 selects zero-suppressed mode |
| strip_pat | input | 128 | Strip hit pattern |
| arr_time | input | 50 | Event arrival time |
| chamber_id | input | 16 | Chamber identifier |
| rec_data | output | 32 | Record word |
| rec_valid | output | 1 | Record word valid |
| rec_ready | input | 1 | Downstream accepts word |
| rec_last | output | 1 | Final word of record |
| busy | output | 1 | Record in progress |
| drop_cnt | output | 16 | Dropped trigger count |

## Verification
The records are tried with the following hit patterns, and each one separates a different fault:
- Empty events in both modes. These separate the full-mode layout of sixteen words from the header-only zero-suppressed record.
- A staircase where group c holds c hits. This exposes wrong per-group counts, length sums and hit ordering.
- A sweep that puts a single hit in each group in turn. This shows whether group skipping works for every position, including the first and the last.
- Over-filled groups and a worst-case event with every group full. These test truncation, the overflow flag and the longest record.
- Triggers and hits injected in the middle of a record, with ready toggling. These test the drop counter, the clearing of the store and the holding of data under backpressure.

// File: rtl/ev_rec_pkg.sv
package ev_rec_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_WORDS = 8;
  localparam int STRIP_W   = 128;
  localparam int ARR_W     = 50;
  localparam int LEN_W     = 14;

  localparam logic [1:0] MODE_FULL = 2'b00;
  localparam logic [1:0] MODE_ZS   = 2'b01;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HDR  = 2'd1,
    SQ_CHW  = 2'd2,
    SQ_HIT  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/ev_hit_store.sv
module ev_hit_store #(
  parameter int NUM_CH   = 8,
  parameter int MAX_HITS = 16,
  parameter int TIME_W   = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int HIT_W   = $clog2(MAX_HITS),
  localparam int CNT_W   = $clog2(MAX_HITS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic [TIME_W-1:0]       wr_start,
  input  logic [TIME_W-1:0]       wr_stop,
  input  logic                    clr,
  input  logic [CH_W-1:0]         rd_ch,
  input  logic [HIT_W-1:0]        rd_idx,
  output logic [2*TIME_W-1:0]     rd_data,
  output logic [NUM_CH*CNT_W-1:0] cnt_flat,
  output logic [NUM_CH-1:0]       ovf
);
  logic [2*TIME_W-1:0] rd_row [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                ovf_q, ovf_d;
    logic [2*TIME_W-1:0] mem_q [MAX_HITS];
    logic                sel, full, wr_ok;

    assign sel   = wr_en && (wr_ch == CH_W'(c));
    assign full  = (cnt_q == CNT_W'(MAX_HITS));
    assign wr_ok = sel && !full;

    always_comb begin
      cnt_d = cnt_q;
      ovf_d = ovf_q;
      if (clr) begin
        cnt_d = '0;
        ovf_d = 1'b0;
      end else if (sel) begin
        if (full) ovf_d = 1'b1;
        else      cnt_d = cnt_q + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        ovf_q <= ovf_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_ok && !clr) mem_q[cnt_q[HIT_W-1:0]] <= {wr_start, wr_stop};
    end

    assign rd_row[c]                  = mem_q[rd_idx];
    assign cnt_flat[c*CNT_W +: CNT_W] = cnt_q;
    assign ovf[c]                     = ovf_q;
  end

  assign rd_data = rd_row[rd_ch];
endmodule

// File: rtl/ev_len_calc.sv
module ev_len_calc
  import ev_rec_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int MAX_HITS = 16,
  localparam int CNT_W   = $clog2(MAX_HITS + 1)
) (
  input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input  logic                    zs,
  output logic [LEN_W-1:0]        len
);
  always_comb begin
    len = LEN_W'(HDR_WORDS);
    for (int c = 0; c < NUM_CH; c++) begin
      if (!zs || (cnt_flat[c*CNT_W +: CNT_W] != '0))
        len = len + LEN_W'(1) + LEN_W'(cnt_flat[c*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/ev_rec_seq.sv
module ev_rec_seq
  import ev_rec_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int MAX_HITS = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int HIT_W   = $clog2(MAX_HITS),
  localparam int CNT_W   = $clog2(MAX_HITS + 1),
  localparam int IDX_W   = $clog2(HDR_WORDS),
  localparam int PAD_W   = WORD_W - 17 - CNT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        zs,
  input  logic [NUM_CH*CNT_W-1:0]     cnt_flat,
  input  logic [NUM_CH-1:0]           ovf,
  input  logic [HDR_WORDS*WORD_W-1:0] hdr_flat,
  input  logic [WORD_W-1:0]           hit_word,
  input  logic                        out_ready,
  output logic [WORD_W-1:0]           out_data,
  output logic                        out_valid,
  output logic                        out_last,
  output logic                        busy,
  output logic                        done,
  output logic [CH_W-1:0]             rd_ch,
  output logic [HIT_W-1:0]            rd_idx
);
  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [HIT_W-1:0] hit_q, hit_d;

  logic             has0, hasn, fire, hit_end;
  logic [CH_W-1:0]  f0, fn;
  logic [CNT_W-1:0] cur_cnt;

  assign cur_cnt = cnt_flat[ch_q*CNT_W +: CNT_W];
  assign hit_end = (CNT_W'(hit_q) == (cur_cnt - CNT_W'(1)));

  // Lowest group to send, and next group to send after the current one.
  always_comb begin
    has0 = 1'b0;
    hasn = 1'b0;
    f0   = '0;
    fn   = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (!zs || (cnt_flat[c*CNT_W +: CNT_W] != '0)) begin
        has0 = 1'b1;
        f0   = CH_W'(c);
        if (CH_W'(c) > ch_q) begin
          hasn = 1'b1;
          fn   = CH_W'(c);
        end
      end
    end
  end

  assign out_valid = (st_q != SQ_IDLE);
  assign busy      = out_valid;
  assign fire      = out_valid && out_ready;
  assign done      = fire && out_last;
  assign rd_ch     = ch_q;
  assign rd_idx    = hit_q;

  always_comb begin
    out_last = 1'b0;
    out_data = '0;
    case (st_q)
      SQ_HDR: begin
        out_data = hdr_flat[idx_q*WORD_W +: WORD_W];
        out_last = (idx_q == IDX_W'(HDR_WORDS - 1)) && !has0;
      end
      SQ_CHW: begin
        out_data = {ovf[ch_q], {PAD_W{1'b0}}, cur_cnt, 16'(ch_q)};
        out_last = (cur_cnt == '0) && !hasn;
      end
      SQ_HIT: begin
        out_data = hit_word;
        out_last = hit_end && !hasn;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    ch_d  = ch_q;
    hit_d = hit_q;
    case (st_q)
      SQ_IDLE: if (start) begin
        st_d  = SQ_HDR;
        idx_d = '0;
      end
      SQ_HDR: if (fire) begin
        if (idx_q != IDX_W'(HDR_WORDS - 1)) idx_d = idx_q + IDX_W'(1);
        else if (has0) begin
          st_d = SQ_CHW;
          ch_d = f0;
        end else st_d = SQ_IDLE;
      end
      SQ_CHW: if (fire) begin
        if (cur_cnt != '0) begin
          st_d  = SQ_HIT;
          hit_d = '0;
        end else if (hasn) ch_d = fn;
        else st_d = SQ_IDLE;
      end
      SQ_HIT: if (fire) begin
        if (!hit_end) hit_d = hit_q + HIT_W'(1);
        else if (hasn) begin
          st_d = SQ_CHW;
          ch_d = fn;
        end else st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      ch_q  <= '0;
      hit_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      ch_q  <= ch_d;
      hit_q <= hit_d;
    end
  end
endmodule

// File: rtl/ev_record_builder.sv
module ev_record_builder
  import ev_rec_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int MAX_HITS = 16,
  parameter int TIME_W   = 16,
  parameter int DROP_W   = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int HIT_W   = $clog2(MAX_HITS),
  localparam int CNT_W   = $clog2(MAX_HITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_valid,
  input  logic [CH_W-1:0]     hit_chan,
  input  logic [TIME_W-1:0]   hit_start,
  input  logic [TIME_W-1:0]   hit_stop,
  input  logic                trig,
  input  logic [31:0]         trig_evt,
  input  logic                trig_zs,
  input  logic [STRIP_W-1:0]  strip_pat,
  input  logic [ARR_W-1:0]    arr_time,
  input  logic [15:0]         chamber_id,
  output logic [WORD_W-1:0]   rec_data,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic                rec_last,
  output logic                busy,
  output logic [DROP_W-1:0]   drop_cnt
);
  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  logic                accept, drop, clr, wr_en;
  logic [STRIP_W-1:0]  strip_q;
  logic [ARR_W-1:0]    arr_q;
  logic [15:0]         cham_q;
  logic [31:0]         evt_q;
  logic                zs_q, zs_d;
  logic [DROP_W-1:0]   drop_q, drop_d;
  logic [LEN_W-1:0]    len;
  logic [15:0]         pkt;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [NUM_CH-1:0]   ovf;
  logic [CH_W-1:0]     rd_ch;
  logic [HIT_W-1:0]    rd_idx;
  logic [2*TIME_W-1:0] rd_data;
  logic [HDR_WORDS*WORD_W-1:0] hdr_flat;

  assign accept = trig && !busy;
  assign drop   = trig && busy;
  assign wr_en  = hit_valid && !busy && !trig;

  always_comb begin
    zs_d   = accept ? trig_zs : zs_q;
    drop_d = drop_q;
    if (drop && (drop_q != '1)) drop_d = drop_q + DROP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      zs_q   <= 1'b0;
      drop_q <= '0;
    end else begin
      zs_q   <= zs_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      strip_q <= strip_pat;
      arr_q   <= arr_time;
      cham_q  <= chamber_id;
      evt_q   <= trig_evt;
    end
  end

  assign drop_cnt = drop_q;
  assign pkt      = {(zs_q ? MODE_ZS : MODE_FULL), len};
  assign hdr_flat = {strip_q[31:0], strip_q[63:32], strip_q[95:64], strip_q[127:96],
                     arr_q[31:0], {(2*WORD_W-ARR_W){1'b0}}, arr_q[ARR_W-1:32],
                     cham_q, pkt, evt_q};

  ev_hit_store #(.NUM_CH(NUM_CH), .MAX_HITS(MAX_HITS), .TIME_W(TIME_W)) u_store (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_ch(hit_chan),
    .wr_start(hit_start), .wr_stop(hit_stop), .clr(clr),
    .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_data(rd_data),
    .cnt_flat(cnt_flat), .ovf(ovf)
  );

  ev_len_calc #(.NUM_CH(NUM_CH), .MAX_HITS(MAX_HITS)) u_len (
    .cnt_flat(cnt_flat), .zs(zs_q), .len(len)
  );

  ev_rec_seq #(.NUM_CH(NUM_CH), .MAX_HITS(MAX_HITS)) u_seq (
    .clk(clk), .rst_n(rst_q), .start(accept), .zs(zs_q),
    .cnt_flat(cnt_flat), .ovf(ovf), .hdr_flat(hdr_flat),
    .hit_word(WORD_W'(rd_data)), .out_ready(rec_ready),
    .out_data(rec_data), .out_valid(rec_valid), .out_last(rec_last),
    .busy(busy), .done(clr), .rd_ch(rd_ch), .rd_idx(rd_idx)
  );
endmodule

// File: rtl/ev_record_builder_chk.sv
module ev_record_builder_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              busy,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic              rec_last,
  input logic [31:0]       rec_data,
  input logic [DROP_W-1:0] drop_cnt
);
  AST_START_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy) |=> (busy && rec_valid)); // R2

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data))); // R9

  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && (drop_cnt != '1)) |=> (drop_cnt == DROP_W'($past(drop_cnt) + 1'b1))); // R8

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && trig) |=> $stable(drop_cnt)); // R8

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && rec_last) |=> !busy); // R10

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> busy); // R10
endmodule

bind ev_record_builder ev_record_builder_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .trig(trig), .busy(busy), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rec_last(rec_last), .rec_data(rec_data), .drop_cnt(drop_cnt)
);

// File: tb/sim_ev_record_builder.sv
module sim_ev_record_builder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hit_valid = 1'b0;
  logic [2:0]   hit_chan = '0;
  logic [15:0]  hit_start = '0, hit_stop = '0;
  logic         trig = 1'b0;
  logic [31:0]  trig_evt = '0;
  logic         trig_zs = 1'b0;
  logic [127:0] strip_pat = '0;
  logic [49:0]  arr_time = '0;
  logic [15:0]  chamber_id = '0;
  logic [31:0]  rec_data;
  logic         rec_valid, rec_ready = 1'b0, rec_last, busy;
  logic [15:0]  drop_cnt;

  ev_record_builder u0 (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int          m_cnt [8];
  bit          m_ovf [8];
  logic [31:0] m_hit [8][16];
  logic [31:0] exp_w [256];
  string       exp_t [256];
  int          exp_n;
  int          exp_drops = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 8; c++) begin
      m_cnt[c] = 0;
      m_ovf[c] = 0;
    end
  endtask

  task automatic add_hit(input int c, input logic [15:0] s, input logic [15:0] p);
    @(negedge clk);
    hit_valid = 1; hit_chan = 3'(c); hit_start = s; hit_stop = p;
    @(negedge clk);
    hit_valid = 0;
    if (m_cnt[c] < 16) begin
      m_hit[c][m_cnt[c]] = {s, p};
      m_cnt[c]++;
    end else m_ovf[c] = 1;
  endtask

  task automatic fire(input bit zs, input logic [31:0] evt);
    logic [13:0] len;
    chamber_id = 16'(evt * 3 + 16'h0a51);
    arr_time   = {18'(evt ^ 18'h2b3c1), 32'(evt * 32'h9e3779b1)};
    strip_pat  = {evt, ~evt, evt + 32'h1234, evt ^ 32'h5a5a5a5a};
    trig_evt   = evt;
    trig_zs    = zs;
    len = 8;
    for (int c = 0; c < 8; c++) if (!zs || m_cnt[c] != 0) len += 14'(1 + m_cnt[c]);
    exp_w[0] = evt;                                exp_t[0] = "R2";
    exp_w[1] = {chamber_id, zs ? 2'b01 : 2'b00, len}; exp_t[1] = "R3";
    exp_w[2] = {14'b0, arr_time[49:32]};           exp_t[2] = "R2";
    exp_w[3] = arr_time[31:0];                     exp_t[3] = "R2";
    exp_w[4] = strip_pat[127:96];                  exp_t[4] = "R2";
    exp_w[5] = strip_pat[95:64];                   exp_t[5] = "R2";
    exp_w[6] = strip_pat[63:32];                   exp_t[6] = "R2";
    exp_w[7] = strip_pat[31:0];                    exp_t[7] = "R2";
    exp_n = 8;
    for (int c = 0; c < 8; c++) begin
      if (!zs || m_cnt[c] != 0) begin
        exp_w[exp_n] = {m_ovf[c], 10'b0, 5'(m_cnt[c]), 16'(c)};
        exp_t[exp_n] = m_ovf[c] ? "R7" : (zs ? "R6" : "R4");
        exp_n++;
        for (int h = 0; h < m_cnt[c]; h++) begin
          exp_w[exp_n] = m_hit[c][h];
          exp_t[exp_n] = "R5";
          exp_n++;
        end
      end
    end
    @(negedge clk);
    rec_ready = 0; trig = 1;
    @(negedge clk);
    trig = 0;
    chk(busy && rec_valid, "R2 start", {30'b0, busy, rec_valid}, 32'h3);
  endtask

  task automatic collect(input int rdy_mode, input int drop_at);
    int k = 0, guard = 0;
    logic [31:0] held = '0;
    bit pend = 0, injected = 0;
    while (k < exp_n && guard < 3000) begin
      @(negedge clk);
      guard++;
      trig = 0; hit_valid = 0;
      if (pend) begin
        chk(rec_valid && rec_data == held, "R9", rec_data, held);
        pend = 0;
      end
      rec_ready = (rdy_mode == 0) ? 1'b1 : ((guard % 3) != 0);
      if (k == drop_at && !injected) begin
        trig = 1; hit_valid = 1; hit_chan = 0; hit_start = 16'h7777; hit_stop = 16'h8888;
        injected = 1;
        exp_drops++;
      end
      if (rec_valid && rec_ready) begin
        chk(rec_data == exp_w[k], exp_t[k], rec_data, exp_w[k]);
        chk(rec_last == (k == exp_n - 1), "R10 last", 32'(rec_last), 32'(k == exp_n - 1));
        k++;
      end else if (rec_valid) begin
        held = rec_data;
        pend = 1;
      end
    end
    if (guard >= 3000) chk(0, "watchdog", 32'(k), 32'(exp_n));
    @(negedge clk);
    rec_ready = 0; trig = 0; hit_valid = 0;
    chk(!busy && !rec_valid, "R10 idle", {30'b0, busy, rec_valid}, 32'h0);
    clear_model();
  endtask

  task automatic record(input bit zs, input logic [31:0] evt, input int rdy_mode, input int drop_at);
    fire(zs, evt);
    collect(rdy_mode, drop_at);
  endtask

  initial begin
    #1200000;
    chk(0, "watchdog", 32'(n_chk), 32'h0);
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !rec_valid && drop_cnt == 0, "R1", {busy, rec_valid, 14'b0, drop_cnt}, 32'h0);

    // R4 empty event, full mode: 16 words
    record(0, 32'h1000_0001, 0, -1);
    // R6 empty event, zero-suppressed: header only
    record(1, 32'h1000_0002, 0, -1);

    // R5 staircase: group c holds c hits, both modes, with backpressure (R9)
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++)
        for (int h = 0; h < c; h++)
          add_hit(c, 16'(c * 256 + h * 7 + m), 16'(c * 256 + h * 7 + m + 100));
      record(m[0], 32'h2000_0000 + 32'(m), 1, -1);
    end

    // R6 sweep: single hit in each group in turn
    for (int c = 0; c < 8; c++) begin
      add_hit(c, 16'(c * 11 + 1), 16'(c * 13 + 500));
      record(1, 32'h3000_0000 + 32'(c), c % 2, -1);
    end

    // R7 overflow: group 5 gets 20 hits, group 0 exactly 16
    for (int h = 0; h < 20; h++) add_hit(5, 16'(h + 40), 16'(h + 900));
    for (int h = 0; h < 16; h++) add_hit(0, 16'(h + 4000), 16'(h + 4500));
    record(1, 32'h4000_0000, 0, -1);
    record(0, 32'h4000_0001, 0, -1);

    // R8 trigger and hit during a record
    for (int h = 0; h < 3; h++) add_hit(2, 16'(h + 60), 16'(h + 70));
    record(0, 32'h5000_0000, 1, 4);
    chk(drop_cnt == 16'(exp_drops), "R8 count", 32'(drop_cnt), 32'(exp_drops));
    repeat (3) begin
      @(negedge clk);
      chk(!rec_valid, "R8 no queue", 32'(rec_valid), 32'h0);
    end
    // R10 store cleared, busy-time hit discarded
    record(0, 32'h5000_0001, 0, 10);
    chk(drop_cnt == 16'(exp_drops), "R8 count", 32'(drop_cnt), 32'(exp_drops));

    // Worst case: all groups full
    for (int c = 0; c < 8; c++)
      for (int h = 0; h < 16; h++) add_hit(c, 16'(c * 100 + h), 16'(c * 100 + h + 3000));
    record(0, 32'h6000_0000, 1, -1);

    finish_run();
  end
endmodule